// File: doc/BRIEF.md
# Addressed Shift-Register SPI Slave

This block is an SPI slave meant to share one bus with many identical devices. Clock, data-in, data-out and a single active-low select run in parallel to every device. Each frame opens with a 16-bit address, sent MSB first. The top four address bits name one device: three bits must equal the board switch inputs, and the fourth must equal a hard-wired device pin. Every device runs the same logic and decodes its own slice of the address space. A device that is not named ignores the rest of the frame and never enables its data-out driver.

A named device then reads or writes a 72-bit test vector. A write moves the 72 received bits into an output register that drives the test pins. The register changes only once the last bit has arrived. A read returns the 72 test-pin inputs, captured when the data phase begins. A read of internal address zero returns a fixed identification word instead, so a master can find out which devices are fitted.

The bus is SPI mode 0. Data is sampled on the rising SCK edge and changed on the falling edge. All bus inputs are brought into the system clock domain through two-flop synchronizers.

Top module: `spi_addr_slave`

## Requirements
- R1: After reset, the test outputs are all zero and the data-out enable is low.
- R2: The 16-bit address (MSB first) is laid out as follows: bits 15..13 give the board ID, bit 12 gives the device ID, bits 11..1 give the internal address, and bit 0 is the direction bit. The device is selected only when bits 15..13 equal `boardSw` and bit 12 equals `devPin`.
- R3: An unselected device leaves the test outputs unchanged and keeps the data-out enable low for the whole frame.
- R4: Direction bit value 1 is a write and value 0 is a read. A write never enables data-out.
- R5: A write to a non-zero internal address loads the 72 data bits (first bit = MSB) into the test outputs. The outputs change only after the 72nd bit.
- R6: A read of a non-zero internal address returns `pinsIn`, captured at the first falling SCK after the direction bit, MSB first. The first bit is valid before the next rising SCK.
- R7: At internal address 0, a read returns 16'hC5A3 followed by 56 zero bits, and a write leaves the test outputs unchanged.
- R8: The data-out enable is high only during the 72-bit data phase of a selected read. It is low one clock after select goes high.
- R9: If select deasserts before the 72nd data bit, the partial frame is discarded and the test outputs keep their previous value.
- R10: Bits clocked after the 72nd data bit are ignored, both by the test outputs and by the data-out enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sckIn | input | 1 | SPI serial clock |
| csNIn | input | 1 | SPI select, active low, shared by all devices |
| mosiIn | input | 1 | Serial data from the master |
| boardSw | input | 3 | Board ID switch value |
| devPin | input | 1 | Hard-wired device ID bit |
| pinsIn | input | 72 | Captured test-pin state |
| misoOut | output | 1 | Serial data to the master |
| misoEn | output | 1 | Enable for the shared data-out driver |
| pinsOut | output | 72 | Test vector output register |

## Verification
Each bus input passes through two synchronizer flops and one edge-detect flop. An SCK edge therefore takes effect three system clocks after it reaches the pins. The bench holds each SCK half period for eight clocks, so every result settles well inside one half period. Data-out and its enable are sampled one clock before the bench raises SCK, which is where a master would sample them. The test outputs are compared two half periods after select is released, by which time a commit, or the absence of one, is final. Expected values come from a queue filled by the driver task. A monitor process pops each value and compares it with the result the frame produced.

// File: rtl/spi_addr_pkg.sv
package spi_addr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_SKIP} frame_st_t;

  typedef struct packed {
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic commit;
    logic useId;
  } strobe_t;
endpackage

// File: rtl/spi_addr_ctrl.sv
module spi_addr_ctrl
  import spi_addr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BOARD_W = 3,
  parameter int DATA_W  = 72
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sckIn,
  input  logic               csNIn,
  input  logic               mosiIn,
  input  logic [BOARD_W-1:0] boardSw,
  input  logic               devPin,
  input  logic [ADDR_W-1:0]  addrWord,
  output logic               mosiBit,
  output logic               misoEn,
  output strobe_t            strb
);
  localparam int CNT_W   = $clog2(DATA_W);
  localparam int DEV_BIT = ADDR_W - BOARD_W - 1;
  localparam int INT_W   = DEV_BIT - 1;

  logic [2:0] sckSync;
  logic [1:0] csSync;
  logic [1:0] mosiSync;
  frame_st_t  state;
  logic [CNT_W-1:0] bitCnt;
  logic isWrite, isIdAddr, misoEnQ;
  logic sckRise, sckFall, csActive, idMatch, addrDone, dataDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      csSync   <= '1;
      mosiSync <= '0;
    end else begin
      sckSync  <= {sckSync[1:0], sckIn};
      csSync   <= {csSync[0], csNIn};
      mosiSync <= {mosiSync[0], mosiIn};
    end
  end

  assign sckRise  = sckSync[1] & ~sckSync[2];
  assign sckFall  = ~sckSync[1] & sckSync[2];
  assign csActive = ~csSync[1];
  assign mosiBit  = mosiSync[1];
  assign idMatch  = (addrWord[ADDR_W-1 -: BOARD_W] == boardSw) && (addrWord[DEV_BIT] == devPin);
  assign addrDone = sckRise && (state == ST_ADDR) && (bitCnt == CNT_W'(ADDR_W - 1));
  assign dataDone = sckRise && (state == ST_DATA) && (bitCnt == CNT_W'(DATA_W - 1));

  always_comb begin
    strb         = '0;
    strb.useId   = isIdAddr;
    strb.shiftIn = csActive && sckRise && (state == ST_ADDR || state == ST_DATA);
    strb.commit  = csActive && dataDone && isWrite && !isIdAddr;
    strb.loadTx  = csActive && sckFall && (state == ST_DATA) && !isWrite && !misoEnQ;
    strb.shiftTx = csActive && sckFall && (state == ST_DATA) && !isWrite && misoEnQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      isWrite  <= 1'b0;
      isIdAddr <= 1'b0;
      misoEnQ  <= 1'b0;
    end else if (!csActive) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      misoEnQ <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          state  <= ST_ADDR;
          bitCnt <= '0;
        end
        ST_ADDR: if (sckRise) begin
          if (addrDone) begin
            bitCnt   <= '0;
            isWrite  <= addrWord[0];
            isIdAddr <= (addrWord[INT_W:1] == '0);
            state    <= idMatch ? ST_DATA : ST_SKIP;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (strb.loadTx) misoEnQ <= 1'b1;
          if (dataDone) begin
            state   <= ST_SKIP;
            misoEnQ <= 1'b0;
          end else if (sckRise) begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= ST_SKIP;
      endcase
    end
  end

  assign misoEn = misoEnQ;

  a_r8_release_on_deselect: assert property (@(posedge clk) disable iff (!rstN)
    csSync[1] |=> !misoEn);
  a_r3_skip_silent: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !misoEn);
  a_r4_write_never_drives: assert property (@(posedge clk) disable iff (!rstN)
    (isWrite && state == ST_DATA) |-> !misoEn);
endmodule

// File: rtl/spi_addr_datapath.sv
module spi_addr_datapath
  import spi_addr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 72,
  parameter int ID_W    = 16,
  parameter logic [ID_W-1:0] ID_WORD = 16'hC5A3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              mosiBit,
  input  logic [DATA_W-1:0] pinsIn,
  output logic [ADDR_W-1:0] addrWord,
  output logic              misoOut,
  output logic [DATA_W-1:0] pinsOut
);
  localparam int PAD_W = DATA_W - ID_W;

  logic [DATA_W-1:0] rxSr;
  logic [DATA_W-1:0] txSr;
  logic [DATA_W-1:0] rxNext;

  assign rxNext   = {rxSr[DATA_W-2:0], mosiBit};
  assign addrWord = rxNext[ADDR_W-1:0];
  assign misoOut  = txSr[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSr    <= '0;
      txSr    <= '0;
      pinsOut <= '0;
    end else begin
      if (strb.shiftIn) rxSr <= rxNext;
      if (strb.commit)  pinsOut <= rxNext;
      if (strb.loadTx)
        txSr <= strb.useId ? {ID_WORD, {PAD_W{1'b0}}} : pinsIn;
      else if (strb.shiftTx)
        txSr <= {txSr[DATA_W-2:0], 1'b0};
    end
  end

  a_r5_pins_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(pinsOut));
  a_r6_tx_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadTx, strb.shiftTx, strb.commit}));
endmodule

// File: rtl/spi_addr_slave.sv
module spi_addr_slave
  import spi_addr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BOARD_W = 3,
  parameter int DATA_W  = 72,
  parameter int ID_W    = 16,
  parameter logic [ID_W-1:0] ID_WORD = 16'hC5A3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sckIn,
  input  logic               csNIn,
  input  logic               mosiIn,
  input  logic [BOARD_W-1:0] boardSw,
  input  logic               devPin,
  input  logic [DATA_W-1:0]  pinsIn,
  output logic               misoOut,
  output logic               misoEn,
  output logic [DATA_W-1:0]  pinsOut
);
  strobe_t           strb;
  logic              mosiBit;
  logic [ADDR_W-1:0] addrWord;

  spi_addr_ctrl #(.ADDR_W(ADDR_W), .BOARD_W(BOARD_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csNIn(csNIn), .mosiIn(mosiIn),
    .boardSw(boardSw), .devPin(devPin), .addrWord(addrWord),
    .mosiBit(mosiBit), .misoEn(misoEn), .strb(strb)
  );

  spi_addr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .ID_WORD(ID_WORD)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiBit(mosiBit), .pinsIn(pinsIn),
    .addrWord(addrWord), .misoOut(misoOut), .pinsOut(pinsOut)
  );
endmodule

// File: tb/tb_spi_addr_slave.sv
`timescale 1ns/1ps
module tb_spi_addr_slave;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0, csNIn = 1'b1, mosiIn = 1'b0, devPin = 1'b1;
  logic [2:0]  boardSw = 3'b101;
  logic [71:0] pinsIn = '0;
  logic        misoOut, misoEn;
  logic [71:0] pinsOut;

  int nRun = 0, nFail = 0;
  bit doneFlag = 0;
  logic [71:0] expQ[$];
  logic [71:0] actQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  spi_addr_slave dut (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csNIn(csNIn), .mosiIn(mosiIn),
    .boardSw(boardSw), .devPin(devPin), .pinsIn(pinsIn),
    .misoOut(misoOut), .misoEn(misoEn), .pinsOut(pinsOut)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect72(input string tag, input logic [71:0] act, input logic [71:0] exp);
    tagQ.push_back(tag);
    expQ.push_back(exp);
    actQ.push_back(act);
  endtask

  // monitor: pops expected items and compares with results
  initial begin
    forever begin
      @(negedge clk);
      while (actQ.size() > 0) begin
        logic [71:0] a, e;
        string t;
        a = actQ.pop_front(); e = expQ.pop_front(); t = tagQ.pop_front();
        nRun++;
        if (a !== e) begin
          nFail++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  // one frame: address, then nData bits taken MSB first from data
  task automatic xfer(input logic [15:0] addr, input logic [79:0] data, input int nData,
                      output logic [71:0] rx, output int enData, output int enAddr);
    int total;
    total = 16 + nData;
    rx = '0; enData = 0; enAddr = 0;
    csNIn = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < total; i++) begin
      mosiIn = (i < 16) ? addr[15-i] : data[79-(i-16)];
      waitClk(HALF - 1);
      if (i >= 16 && i < 88) begin
        rx[71-(i-16)] = misoOut;
        if (misoEn) enData++;
      end else if (misoEn) begin
        enAddr++;
      end
      waitClk(1);
      sckIn = 1'b1;
      waitClk(HALF);
      sckIn = 1'b0;
    end
    waitClk(HALF);
    csNIn = 1'b1;
    waitClk(2 * HALF);
  endtask

  function automatic logic [15:0] mkAddr(input logic [2:0] b, input logic d,
                                         input logic [10:0] ia, input logic rw);
    return {b, d, ia, rw};
  endfunction

  localparam logic [71:0] D1 = 72'hA5_0123_4567_89AB_CDEF;
  localparam logic [71:0] D2 = 72'h3C_FEDC_BA98_7654_3210;
  localparam logic [71:0] P1 = 72'h81_55AA_00FF_1234_5678;

  initial begin
    logic [71:0] rx;
    int enD, enA;
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    expect72("R1 reset pinsOut", pinsOut, 72'h0);
    expect72("R1 reset misoEn", {71'h0, misoEn}, 72'h0);

    xfer(mkAddr(3'b101, 1'b1, 11'h005, 1'b1), {D1, 8'h00}, 72, rx, enD, enA);
    expect72("R5 R2 write commits", pinsOut, D1);
    expect72("R4 write never drives", 72'(enD + enA), 72'h0);

    pinsIn = P1;
    xfer(mkAddr(3'b101, 1'b1, 11'h005, 1'b0), {72'h0, 8'h00}, 72, rx, enD, enA);
    expect72("R6 read returns pins", rx, P1);
    expect72("R8 en high over data phase", 72'(enD), 72'd72);
    expect72("R8 en low over address", 72'(enA), 72'h0);
    expect72("R8 en low after select", {71'h0, misoEn}, 72'h0);

    xfer(mkAddr(3'b101, 1'b1, 11'h000, 1'b0), {72'h0, 8'h00}, 72, rx, enD, enA);
    expect72("R7 id read", rx, {16'hC5A3, 56'h0});

    xfer(mkAddr(3'b101, 1'b1, 11'h000, 1'b1), {D2, 8'h00}, 72, rx, enD, enA);
    expect72("R7 write to id address ignored", pinsOut, D1);

    xfer(mkAddr(3'b100, 1'b1, 11'h005, 1'b1), {D2, 8'h00}, 72, rx, enD, enA);
    expect72("R3 wrong board write ignored", pinsOut, D1);

    xfer(mkAddr(3'b101, 1'b0, 11'h005, 1'b0), {72'h0, 8'h00}, 72, rx, enD, enA);
    expect72("R3 wrong device no drive", 72'(enD + enA), 72'h0);

    xfer(mkAddr(3'b101, 1'b1, 11'h005, 1'b1), {D2, 8'h00}, 71, rx, enD, enA);
    expect72("R9 aborted write discarded", pinsOut, D1);

    xfer(mkAddr(3'b101, 1'b1, 11'h7FF, 1'b1), {D2, 8'hFF}, 80, rx, enD, enA);
    expect72("R10 extra bits ignored", pinsOut, D2);

    xfer(mkAddr(3'b101, 1'b1, 11'h7FF, 1'b0), {72'h0, 8'hFF}, 80, rx, enD, enA);
    expect72("R10 en low after data phase", 72'(enA), 72'h0);
    expect72("R6 read at top address", rx, P1);

    boardSw = 3'b010; devPin = 1'b0;
    waitClk(4);
    xfer(mkAddr(3'b010, 1'b0, 11'h123, 1'b1), {D1, 8'h00}, 72, rx, enD, enA);
    expect72("R2 new strap value selects", pinsOut, D1);
    xfer(mkAddr(3'b101, 1'b1, 11'h123, 1'b1), {D2, 8'h00}, 72, rx, enD, enA);
    expect72("R2 old strap value rejected", pinsOut, D1);

    waitClk(4);
    doneFlag = 1;
  end

  initial begin
    int cyc = 0;
    while (!doneFlag && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!doneFlag) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    waitClk(2);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule